// File: doc/BRIEF.md
# Square Tone Channel with Prescaler

This block turns a 10-bit period value into a square wave for one tone voice of a simple sound generator. A prescaler divides the master clock by a ratio chosen on two select pins: a standard ratio of 16, no division, or a slow ratio of 128. Each prescaled tick steps a down-counter. When the counter reaches the end of its count, it reloads from the period input and inverts the output bit.

The output is a plain 0/1 level with no DC offset. Each inversion also raises a one-cycle strobe, which a neighbouring noise generator can use as its shift clock. With the standard ratio, the tone frequency is the clock divided by 32 times the period. For example, a 4 MHz clock with period 0x11C gives about 440 Hz. Attenuation and mixing belong to other blocks.

Top module: `tone_square_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `square_o` and `toggle_o` are both 0 after that edge.
- R2: With period P (1..1023) held, `square_o` inverts once every P prescaled ticks. The first tick after reset release inverts it, and each inversion samples `period_i` as the next count.
- R3: Select codes 2'b00 and 2'b11 produce one prescaled tick every 16 clocks. The first inversion shows after clock edge 17 after reset release, and later ones follow every 16*P edges.
- R4: Select code 2'b01 produces a prescaled tick on every clock. The first inversion shows after edge 2, and later ones follow every P edges.
- R5: Select code 2'b10 produces one prescaled tick every 128 clocks. The first inversion shows after edge 129, and later ones follow every 128*P edges.
- R6: A period of 0 behaves the same as a period of 1: the output inverts on every prescaled tick.
- R7: `toggle_o` is high for exactly one clock in each cycle where `square_o` has just changed, and is low otherwise. When the ratio is above 1 it never stays high on two consecutive clocks.
- R8: A change on `period_i` does not disturb the count in progress. It takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 2 | Prescaler ratio select: 00/11 divide by 16, 01 none, 10 divide by 128 |
| period_i | input | 10 | Half-wave length in prescaled ticks |
| square_o | output | 1 | Registered square wave, 0/1 |
| toggle_o | output | 1 | One-clock strobe on each inversion of `square_o` |

## Verification
The assertions assume that `sel_i` changes only while `rst` is held. The single-strobe property compares the strobe with the select value one clock later. That comparison is only meaningful if the ratio is fixed between resets. The bench therefore changes the select code only inside its reset task, which runs at a falling edge. The period, by contrast, may change at any falling edge, and the bench changes it mid-count to exercise the deferred reload.

// File: rtl/tone_pkg.sv
package tone_pkg;
  typedef enum logic [1:0] {
    PS_STD_A = 2'b00,
    PS_NONE  = 2'b01,
    PS_SLOW  = 2'b10,
    PS_STD_B = 2'b11
  } ps_sel_e;
endpackage

// File: rtl/tone_prescaler.sv
module tone_prescaler import tone_pkg::*; #(
  parameter int DIV_STD  = 16,
  parameter int DIV_SLOW = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int PS_W = $clog2(DIV_SLOW);

  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] limit;
  logic            tick_q;
  logic            wrap;

  // Terminal count for the chosen ratio (ratio minus one).
  always_comb begin
    case (ps_sel_e'(sel_i))
      PS_NONE: limit = '0;
      PS_SLOW: limit = PS_W'(DIV_SLOW - 1);
      default: limit = PS_W'(DIV_STD - 1);
    endcase
  end

  assign wrap = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (wrap) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  // Bypass mode ticks on every clock.
  p_bypass_ticks_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_i == 2'b01) |=> tick_q);

  // Dividing modes never tick on two clocks in a row.
  p_tick_sparse_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_q && sel_i != 2'b01) |=> !tick_q);
endmodule

// File: rtl/tone_counter.sv
module tone_counter #(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             square_o,
  output logic             toggle_o
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0] cnt_q;
  logic             sq_q;
  logic             stb_q;
  logic             at_end;

  // Counts of 0 and 1 both end the half wave on this tick.
  assign at_end = (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (tick_i) begin
        if (at_end) begin
          cnt_q <= period_i;
          sq_q  <= ~sq_q;
          stb_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign square_o = sq_q;
  assign toggle_o = stb_q;

  // The strobe marks exactly the cycles where the wave has just changed.
  p_strobe_tracks_wave_r7: assert property (@(posedge clk) disable iff (rst)
    toggle_o == (square_o != $past(square_o)));

  // An inversion needs a prescaled tick on the previous edge.
  p_toggle_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
    toggle_o |-> $past(tick_i));

  // Mid-count ticks just step down; the period input is not looked at.
  p_count_holds_period_r8: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/tone_square_gen.sv
module tone_square_gen #(
  parameter int PER_W    = 10,
  parameter int DIV_STD  = 16,
  parameter int DIV_SLOW = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel_i,
  input  logic [PER_W-1:0] period_i,
  output logic             square_o,
  output logic             toggle_o
);
  logic tick;

  tone_prescaler #(.DIV_STD(DIV_STD), .DIV_SLOW(DIV_SLOW)) u_ps (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (sel_i),
    .tick_o (tick)
  );

  tone_counter #(.PER_W(PER_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .period_i (period_i),
    .square_o (square_o),
    .toggle_o (toggle_o)
  );

  // Reset clears the outputs on the following edge.
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!square_o && !toggle_o));
endmodule

// File: tb/tb_tone_square_gen.sv
`timescale 1ns/1ps
module tb_tone_square_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'b01;
  logic [9:0] per = 10'd1;
  logic       square_o, toggle_o;

  int total = 0;
  int bad = 0;
  bit chk_en = 0;
  string cur_req = "R2";

  always #10 clk = ~clk;

  tone_square_gen dut (
    .clk(clk), .rst(rst), .sel_i(sel), .period_i(per),
    .square_o(square_o), .toggle_o(toggle_o)
  );

  // Behavioural reference: edges since reset, pending tick, ticks left.
  int  m_edge, m_left;
  bit  m_pend, m_sq, m_tg;

  function automatic int ratio_of(logic [1:0] s);
    if (s == 2'b01) return 1;
    if (s == 2'b10) return 128;
    return 16;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_edge = 0; m_left = 0; m_pend = 0; m_sq = 0; m_tg = 0;
    end else begin
      bit now;
      now = m_pend;
      m_tg = 0;
      m_edge++;
      m_pend = (m_edge % ratio_of(sel)) == 0;
      if (now) begin
        if (m_left == 0) begin
          m_sq = !m_sq; m_tg = 1;
          m_left = ((per == 0) ? 1 : int'(per)) - 1;
        end else m_left--;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !rst) begin
      check(cur_req, "square_o vs model", int'(square_o), int'(m_sq));
      check(cur_req, "toggle_o vs model", int'(toggle_o), int'(m_tg));
    end
  end

  task automatic do_reset(logic [1:0] s, logic [9:0] p);
    @(negedge clk);
    rst = 1; sel = s; per = p;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic measure(int maxc, output int t1, output int t2);
    t1 = -1; t2 = -1;
    for (int k = 1; k <= maxc; k++) begin
      @(negedge clk);
      if (toggle_o) begin
        if (t1 < 0) t1 = k;
        else if (t2 < 0) begin t2 = k; break; end
      end
    end
  endtask

  initial begin
    int a, b;
    // R1: reset state after activity
    do_reset(2'b01, 10'd2);
    repeat (7) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    check("R1", "square_o in reset", int'(square_o), 0);
    check("R1", "toggle_o in reset", int'(toggle_o), 0);
    chk_en = 1;

    // R4: no prescaling
    cur_req = "R4";
    do_reset(2'b01, 10'd5);
    measure(100, a, b);
    check("R4", "first toggle edge", a, 2);
    check("R4", "second toggle edge", b, 7);
    repeat (150) @(negedge clk);

    // R3: divide by 16, both codes
    cur_req = "R3";
    do_reset(2'b00, 10'd4);
    measure(500, a, b);
    check("R3", "sel00 first edge", a, 17);
    check("R3", "sel00 second edge", b, 81);
    do_reset(2'b11, 10'd2);
    measure(500, a, b);
    check("R3", "sel11 first edge", a, 17);
    check("R3", "sel11 second edge", b, 49);
    repeat (300) @(negedge clk);

    // R5: divide by 128
    cur_req = "R5";
    do_reset(2'b10, 10'd1);
    measure(1000, a, b);
    check("R5", "sel10 first edge", a, 129);
    check("R5", "sel10 second edge", b, 257);
    do_reset(2'b10, 10'd3);
    repeat (1600) @(negedge clk);

    // R6: period zero equals period one
    cur_req = "R6";
    do_reset(2'b01, 10'd0);
    measure(50, a, b);
    check("R6", "period0 first edge", a, 2);
    check("R6", "period0 second edge", b, 3);
    do_reset(2'b00, 10'd0);
    measure(200, a, b);
    check("R6", "period0 div16 spacing", b - a, 16);

    // R8: period change applies at next reload
    cur_req = "R8";
    do_reset(2'b01, 10'd10);
    measure(20, a, b);
    per = 10'd3;
    check("R8", "change-setup first edge", a, 2);
    measure(40, a, b);
    check("R8", "old period kept", a, 10);
    check("R8", "new period after reload", b - a, 3);

    // R2: 440 Hz setting at divide-by-16
    cur_req = "R2";
    do_reset(2'b00, 10'h11C);
    measure(12000, a, b);
    check("R2", "half-wave clocks for 0x11C", b - a, 4544);
    do_reset(2'b01, 10'd1023);
    measure(3000, a, b);
    check("R2", "half-wave for 1023", b - a, 1023);

    // R7: one strobe per wave change
    cur_req = "R7";
    do_reset(2'b01, 10'd3);
    begin
      int nstb, nchg;
      logic prev;
      nstb = 0; nchg = 0; prev = square_o;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (toggle_o) nstb++;
        if (square_o != prev) nchg++;
        prev = square_o;
      end
      check("R7", "strobes equal wave changes", nstb, nchg);
      check("R7", "changes in 300 clocks", nchg, 100);
    end

    chk_en = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule